// File: doc/BRIEF.md
# Processor Context Save and Restore Sequencer

This block moves processor register state to and from a byte-wide stack in memory, one byte per clock cycle. A request names one of five operations. A subroutine call saves a two-byte return address and then jumps. A subroutine return restores that address. Interrupt entry saves a nine-byte register frame, sets the interrupt mask bit and then loads the program counter from a vector. Return-from-interrupt restores the whole frame. Reset loads the program counter from the reset vector and saves nothing.

The surrounding core supplies its current register values with the request. It reads the updated set from the outputs when `done` pulses. The core decides which source wins arbitration and passes only the chosen vector index.

Memory is a single byte port with a combinational read.

- Pushes write at the stack pointer and then decrement it.
- Pulls increment the stack pointer first and then read.

Top module: `ctx_frame_seq`

## Requirements
- R1: When idle, `reqValid` high on a clock edge starts the operation coded on `reqKind`: 0 call, 1 return, 2 interrupt entry, 3 return-from-interrupt, 4 reset. Codes 5 to 7 start nothing. `busy` is high from the next cycle through the `done` cycle. Requests made while busy are ignored.
- R2: Interrupt entry writes nine bytes, one per cycle, to addresses SP, SP-1, down to SP-8. The bytes go in this order: PC low, PC high, IY low, IY high, IX low, IX high, A, B, CCR. `spOut` is then SP-9.
- R3: After the frame is written, bit 4 of the condition code register (the interrupt mask) is set in `ccrOut`. The stacked CCR byte keeps its original value.
- R4: The vector fetch reads the high byte at 16'hFFFE - 2*`vecSel` and the low byte at the next address. `pcOut` becomes {high, low}. For example, `vecSel` 6 gives $FFF2/$FFF3.
- R5: Return-from-interrupt reads SP+1 up to SP+9 and restores CCR, B, A, IX high, IX low, IY high, IY low, PC high, PC low in that order. `spOut` is then SP+9.
- R6: Reset makes no write. It reads only $FFFE and $FFFF, whatever `vecSel` is. `pcOut` takes the vector, and `spOut` equals `spIn`.
- R7: A call writes PC low at SP and PC high at SP-1. `pcOut` then equals `targetIn` and `spOut` equals SP-2.
- R8: A return reads PC high at SP+1 and PC low at SP+2. `spOut` is then SP+2.
- R9: `done` is a single-cycle pulse. It comes 13 cycles after the accepting edge for interrupt entry, 10 cycles after for return-from-interrupt, and 3 cycles after for the other operations. Memory is accessed only while busy.
- R10: Interrupt entry followed by return-from-interrupt returns every register to its value before entry, including a CCR whose mask bit was clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start request |
| reqKind | input | 3 | Operation code |
| vecSel | input | 3 | Vector index for interrupt entry |
| pcIn | input | 16 | Current PC (return address for a call) |
| iyIn | input | 16 | Current IY |
| ixIn | input | 16 | Current IX |
| accAIn | input | 8 | Current accumulator A |
| accBIn | input | 8 | Current accumulator B |
| ccrIn | input | 8 | Current condition code register |
| spIn | input | 16 | Current stack pointer |
| targetIn | input | 16 | Call destination |
| memRdata | input | 8 | Memory read data, same cycle |
| memValid | output | 1 | Memory access this cycle |
| memWrite | output | 1 | Access is a write |
| memAddr | output | 16 | Byte address |
| memWdata | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Results valid pulse |
| pcOut | output | 16 | Updated PC |
| iyOut | output | 16 | Updated IY |
| ixOut | output | 16 | Updated IX |
| accAOut | output | 8 | Updated A |
| accBOut | output | 8 | Updated B |
| ccrOut | output | 8 | Updated CCR |
| spOut | output | 16 | Updated SP |

## Verification
The assertions check these properties on every cycle:
- Back-to-back stack writes step down by one address, and back-to-back stack reads step up by one.
- No memory access happens while idle.
- Reset never writes.
- `done` never lasts two cycles.
- The mask bit is set whenever an interrupt entry completes.

Only the bench scenarios can show the rest. That covers the byte order of the frame, the vector addresses for each index, the exact cycle of `done`, the restoration of all registers after an entry and return pair, and the dropping of requests made while busy.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  typedef enum logic [2:0] {
    KIND_CALL = 3'd0,
    KIND_RET  = 3'd1,
    KIND_IRQ  = 3'd2,
    KIND_RTI  = 3'd3,
    KIND_RST  = 3'd4
  } reqKind_e;

  // Strobes from control to datapath; at most one of push/pull/vecRd/setMask/load per cycle.
  typedef struct packed {
    logic       load;
    logic       push;
    logic       pull;
    logic       vecRd;
    logic       vecLo;
    logic       setMask;
    logic       jump;
    logic [3:0] slot;   // frame byte index: 0 PCL .. 8 CCR
  } ctlStrobe_t;

  localparam int FRAME_BYTES = 9;
  localparam int RET_BYTES   = 2;
endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  output ctlStrobe_t ctl,
  output logic       memValid,
  output logic       memWrite,
  output logic       busy,
  output logic       done
);
  localparam logic [3:0] FRAME_LAST = 4'(FRAME_BYTES - 1);
  localparam logic [3:0] RET_LAST   = 4'(RET_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_PULL, S_MASK, S_VEC, S_DONE} state_e;

  state_e     state;
  logic [2:0] kindReg;
  logic [3:0] step;
  logic       kindOk;
  logic       isFrame;
  logic [3:0] lastStep;

  assign kindOk   = (reqKind <= KIND_RST);
  assign isFrame  = (kindReg == KIND_IRQ) || (kindReg == KIND_RTI);
  assign lastStep = isFrame ? FRAME_LAST : RET_LAST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kindReg <= KIND_CALL;
      step    <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid && kindOk) begin
          kindReg <= reqKind;
          step    <= '0;
          case (reqKind)
            KIND_CALL, KIND_IRQ: state <= S_PUSH;
            KIND_RET,  KIND_RTI: state <= S_PULL;
            default:             state <= S_VEC;
          endcase
        end
        S_PUSH: if (step == lastStep) begin
          step  <= '0;
          state <= (kindReg == KIND_IRQ) ? S_MASK : S_DONE;
        end else step <= step + 4'd1;
        S_PULL: if (step == lastStep) begin
          step  <= '0;
          state <= S_DONE;
        end else step <= step + 4'd1;
        S_MASK: state <= S_VEC;
        S_VEC: if (step[0]) begin
          step  <= '0;
          state <= S_DONE;
        end else step <= step + 4'd1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == S_IDLE) && reqValid && kindOk;
    ctl.push    = (state == S_PUSH);
    ctl.pull    = (state == S_PULL);
    ctl.vecRd   = (state == S_VEC);
    ctl.vecLo   = step[0];
    ctl.setMask = (state == S_MASK);
    ctl.jump    = ctl.push && (kindReg == KIND_CALL) && (step == RET_LAST);
    if (ctl.push)      ctl.slot = step;
    else if (ctl.pull) ctl.slot = lastStep - step;
  end

  assign memValid = ctl.push || ctl.pull || ctl.vecRd;
  assign memWrite = ctl.push;
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);
endmodule

// File: rtl/ctx_seq_dp.sv
module ctx_seq_dp
  import ctx_seq_pkg::*;
#(
  parameter logic [15:0] VEC_TOP  = 16'hFFFE,
  parameter int          VSEL_W   = 3,
  parameter int          MASK_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [2:0]        reqKind,
  input  logic [VSEL_W-1:0] vecSel,
  input  logic [15:0]       pcIn,
  input  logic [15:0]       iyIn,
  input  logic [15:0]       ixIn,
  input  logic [7:0]        accAIn,
  input  logic [7:0]        accBIn,
  input  logic [7:0]        ccrIn,
  input  logic [15:0]       spIn,
  input  logic [15:0]       targetIn,
  input  logic [7:0]        memRdata,
  output logic [15:0]       memAddr,
  output logic [7:0]        memWdata,
  output logic [15:0]       pcOut,
  output logic [15:0]       iyOut,
  output logic [15:0]       ixOut,
  output logic [7:0]        accAOut,
  output logic [7:0]        accBOut,
  output logic [7:0]        ccrOut,
  output logic [15:0]       spOut
);
  localparam int PAD_W = 15 - VSEL_W;

  logic [15:0]       pcReg, iyReg, ixReg, spReg, tgtReg;
  logic [7:0]        aReg, bReg, ccrReg;
  logic [VSEL_W-1:0] vecSelReg;
  logic [15:0]       vecBase;

  assign vecBase = VEC_TOP - {{PAD_W{1'b0}}, vecSelReg, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg <= '0; iyReg <= '0; ixReg <= '0; spReg <= '0; tgtReg <= '0;
      aReg <= '0; bReg <= '0; ccrReg <= '0; vecSelReg <= '0;
    end else if (ctl.load) begin
      pcReg <= pcIn; iyReg <= iyIn; ixReg <= ixIn; spReg <= spIn;
      aReg <= accAIn; bReg <= accBIn; ccrReg <= ccrIn; tgtReg <= targetIn;
      vecSelReg <= (reqKind == KIND_RST) ? '0 : vecSel;
    end else if (ctl.push) begin
      spReg <= spReg - 16'd1;
      if (ctl.jump) pcReg <= tgtReg;
    end else if (ctl.pull) begin
      spReg <= spReg + 16'd1;
      case (ctl.slot)
        4'd0: pcReg[7:0]  <= memRdata;
        4'd1: pcReg[15:8] <= memRdata;
        4'd2: iyReg[7:0]  <= memRdata;
        4'd3: iyReg[15:8] <= memRdata;
        4'd4: ixReg[7:0]  <= memRdata;
        4'd5: ixReg[15:8] <= memRdata;
        4'd6: aReg        <= memRdata;
        4'd7: bReg        <= memRdata;
        default: ccrReg   <= memRdata;
      endcase
    end else if (ctl.vecRd) begin
      if (ctl.vecLo) pcReg[7:0]  <= memRdata;
      else           pcReg[15:8] <= memRdata;
    end else if (ctl.setMask) begin
      ccrReg[MASK_BIT] <= 1'b1;
    end
  end

  always_comb begin
    case (ctl.slot)
      4'd0:    memWdata = pcReg[7:0];
      4'd1:    memWdata = pcReg[15:8];
      4'd2:    memWdata = iyReg[7:0];
      4'd3:    memWdata = iyReg[15:8];
      4'd4:    memWdata = ixReg[7:0];
      4'd5:    memWdata = ixReg[15:8];
      4'd6:    memWdata = aReg;
      4'd7:    memWdata = bReg;
      default: memWdata = ccrReg;
    endcase
    if (ctl.pull)       memAddr = spReg + 16'd1;
    else if (ctl.vecRd) memAddr = vecBase + {15'd0, ctl.vecLo};
    else                memAddr = spReg;
  end

  assign pcOut = pcReg;  assign iyOut = iyReg;  assign ixOut = ixReg;
  assign accAOut = aReg; assign accBOut = bReg; assign ccrOut = ccrReg;
  assign spOut = spReg;
endmodule

// File: rtl/ctx_frame_seq.sv
module ctx_frame_seq
  import ctx_seq_pkg::*;
#(
  parameter logic [15:0] VEC_TOP  = 16'hFFFE,
  parameter int          VSEL_W   = 3,
  parameter int          MASK_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [VSEL_W-1:0] vecSel,
  input  logic [15:0]       pcIn,
  input  logic [15:0]       iyIn,
  input  logic [15:0]       ixIn,
  input  logic [7:0]        accAIn,
  input  logic [7:0]        accBIn,
  input  logic [7:0]        ccrIn,
  input  logic [15:0]       spIn,
  input  logic [15:0]       targetIn,
  input  logic [7:0]        memRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [15:0]       memAddr,
  output logic [7:0]        memWdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       pcOut,
  output logic [15:0]       iyOut,
  output logic [15:0]       ixOut,
  output logic [7:0]        accAOut,
  output logic [7:0]        accBOut,
  output logic [7:0]        ccrOut,
  output logic [15:0]       spOut
);
  ctlStrobe_t ctl;

  ctx_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .ctl(ctl), .memValid(memValid), .memWrite(memWrite), .busy(busy), .done(done)
  );

  ctx_seq_dp #(.VEC_TOP(VEC_TOP), .VSEL_W(VSEL_W), .MASK_BIT(MASK_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqKind(reqKind), .vecSel(vecSel),
    .pcIn(pcIn), .iyIn(iyIn), .ixIn(ixIn), .accAIn(accAIn), .accBIn(accBIn),
    .ccrIn(ccrIn), .spIn(spIn), .targetIn(targetIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .pcOut(pcOut), .iyOut(iyOut),
    .ixOut(ixOut), .accAOut(accAOut), .accBOut(accBOut), .ccrOut(ccrOut), .spOut(spOut)
  );
endmodule

// File: rtl/ctx_frame_seq_chk.sv
module ctx_frame_seq_chk #(
  parameter int MASK_BIT = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [2:0]  reqKind,
  input logic        memValid,
  input logic        memWrite,
  input logic [15:0] memAddr,
  input logic        busy,
  input logic        done,
  input logic [7:0]  ccrOut
);
  localparam logic [15:0] VEC_FLOOR = 16'hFFF0;
  logic [2:0] kindSeen;

  always_ff @(posedge clk) begin
    if (!rstN) kindSeen <= 3'd0;
    else if (reqValid && !busy) kindSeen <= reqKind;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memValid);
  assert_push_descend_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && $past(memWrite)) |-> memAddr == $past(memAddr) - 16'd1);
  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && kindSeen == 3'd2) |-> ccrOut[MASK_BIT]);
  assert_pull_ascend_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && $past(memValid && !memWrite) &&
     memAddr < VEC_FLOOR && $past(memAddr) < VEC_FLOOR) |-> memAddr == $past(memAddr) + 16'd1);
  assert_reset_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && kindSeen == 3'd4) |-> !memWrite);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_write_needs_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> memValid);
endmodule

bind ctx_frame_seq ctx_frame_seq_chk #(.MASK_BIT(MASK_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
  .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
  .busy(busy), .done(done), .ccrOut(ccrOut)
);

// File: tb/ctx_frame_seq_tb.sv
module ctx_frame_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [2:0] reqKind = '0, vecSel = '0;
  logic [15:0] pcIn = '0, iyIn = '0, ixIn = '0, spIn = '0, targetIn = '0;
  logic [7:0] accAIn = '0, accBIn = '0, ccrIn = '0, memRdata;
  logic memValid, memWrite, busy, done;
  logic [15:0] memAddr, pcOut, iyOut, ixOut, spOut;
  logic [7:0] memWdata, accAOut, accBOut, ccrOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_frame_seq u_dut (.*);

  // memory model: 512 bytes, index {addr[15], addr[7:0]}
  logic [7:0] mem [512];
  logic tbWe = 1'b0; logic [15:0] tbAddr = '0; logic [7:0] tbData = '0;
  assign memRdata = mem[{memAddr[15], memAddr[7:0]}];

  logic [15:0] logAddr [256];
  logic        logWr   [256];
  logic [7:0]  logDat  [256];
  logic [7:0]  logN = '0;

  always @(posedge clk) begin
    if (tbWe) mem[{tbAddr[15], tbAddr[7:0]}] <= tbData;
    else if (memValid && memWrite) mem[{memAddr[15], memAddr[7:0]}] <= memWdata;
    if (rstN && memValid) begin
      logAddr[logN] <= memAddr; logWr[logN] <= memWrite;
      logDat[logN] <= memWrite ? memWdata : memRdata;
      logN <= logN + 8'd1;
    end
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk); tbWe = 1'b0;
  endtask

  function automatic logic [15:0] vecVal(input int vs);
    return {8'hE0 | 8'(vs), 8'(vs * 16 + 3)};
  endfunction

  // start an op, return start log index and cycles to done (accept edge = 0)
  task automatic runOp(input logic [2:0] kind, input logic [2:0] vs, input logic [15:0] sp,
                       output logic [7:0] startIdx, output int cyc);
    @(negedge clk);
    reqKind = kind; vecSel = vs; spIn = sp; reqValid = 1'b1; startIdx = logN;
    @(negedge clk); reqValid = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
  endtask

  localparam logic [90:0] VEC_TAB [4] = '{
    {3'd6, 16'h01FF, 16'hC123, 16'h5A6B, 16'h7C8D, 8'h11, 8'h22, 8'hC0},
    {3'd0, 16'h01A0, 16'h0000, 16'hFFFF, 16'h0001, 8'hFF, 8'h00, 8'h00},
    {3'd7, 16'h0150, 16'h8001, 16'h1234, 16'hABCD, 8'h80, 8'h7F, 8'hEF},
    {3'd3, 16'h0109, 16'hFFFF, 16'h0F0F, 16'hF0F0, 8'h55, 8'hAA, 8'h10}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog R9 actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] st; int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 reset busy", busy, 0);
    chkEq("R9 reset done", done, 0);
    chkEq("R9 reset memValid", memValid, 0);
    for (int v = 0; v < 8; v++) begin
      poke(16'hFFFE - 16'(2 * v), vecVal(v) >> 8);
      poke(16'hFFFF - 16'(2 * v), vecVal(v) & 16'h00FF);
    end

    // table-driven interrupt entry and return
    for (int r = 0; r < 4; r++) begin
      logic [90:0] row; logic [7:0] fb [9]; logic [15:0] sp;
      row = VEC_TAB[r]; sp = row[87:72];
      fb = '{row[63:56], row[71:64], row[47:40], row[55:48], row[31:24], row[39:32],
             row[23:16], row[15:8], row[7:0]};
      pcIn = row[71:56]; iyIn = row[55:40]; ixIn = row[39:24];
      accAIn = row[23:16]; accBIn = row[15:8]; ccrIn = row[7:0];
      runOp(3'd2, row[90:88], sp, st, cyc);
      chkEq("R9 entry done cycle", cyc, 13);
      for (int k = 0; k < 9; k++) begin
        chkEq("R2 frame addr", logAddr[8'(st + k)], sp - 16'(k));
        chkEq("R2 frame byte", {logWr[8'(st + k)], logDat[8'(st + k)]}, {1'b1, fb[k]});
      end
      chkEq("R2 sp after entry", spOut, sp - 16'd9);
      chkEq("R3 mask set", ccrOut, row[7:0] | 8'h10);
      chkEq("R4 vector hi addr", logAddr[8'(st + 9)], 16'hFFFE - 16'(2 * row[90:88]));
      chkEq("R4 vector lo addr", logAddr[8'(st + 10)], 16'hFFFF - 16'(2 * row[90:88]));
      chkEq("R4 pc from vector", pcOut, vecVal(int'(row[90:88])));
      pcIn = 0; iyIn = 0; ixIn = 0; accAIn = 0; accBIn = 0; ccrIn = 0;
      runOp(3'd3, 3'd0, sp - 16'd9, st, cyc);
      chkEq("R9 rti done cycle", cyc, 10);
      chkEq("R5 first pull addr", logAddr[st], sp - 16'd8);
      chkEq("R5 last pull addr", logAddr[8'(st + 8)], sp);
      chkEq("R5 sp after rti", spOut, sp);
      chkEq("R10 pc", pcOut, row[71:56]);
      chkEq("R10 iy", iyOut, row[55:40]);
      chkEq("R10 ix", ixOut, row[39:24]);
      chkEq("R10 a", accAOut, row[23:16]);
      chkEq("R10 b", accBOut, row[15:8]);
      chkEq("R10 ccr", ccrOut, row[7:0]);
    end

    // reset vector: no stacking, vecSel ignored
    runOp(3'd4, 3'd5, 16'h0123, st, cyc);
    chkEq("R9 reset done cycle", cyc, 3);
    chkEq("R6 log count", 8'(logN - st), 2);
    chkEq("R6 read addr hi", {logWr[st], logAddr[st]}, {1'b0, 16'hFFFE});
    chkEq("R6 read addr lo", {logWr[8'(st + 1)], logAddr[8'(st + 1)]}, {1'b0, 16'hFFFF});
    chkEq("R6 pc", pcOut, vecVal(0));
    chkEq("R6 sp", spOut, 16'h0123);

    // call and return
    pcIn = 16'h1234; targetIn = 16'h4567;
    runOp(3'd0, 3'd0, 16'h0180, st, cyc);
    chkEq("R9 call done cycle", cyc, 3);
    chkEq("R7 pcl write", {logAddr[st], logDat[st]}, {16'h0180, 8'h34});
    chkEq("R7 pch write", {logAddr[8'(st + 1)], logDat[8'(st + 1)]}, {16'h017F, 8'h12});
    chkEq("R7 pc target", pcOut, 16'h4567);
    chkEq("R7 sp", spOut, 16'h017E);
    pcIn = 16'h0000;
    runOp(3'd1, 3'd0, 16'h017E, st, cyc);
    chkEq("R9 ret done cycle", cyc, 3);
    chkEq("R8 first read addr", {logWr[st], logAddr[st]}, {1'b0, 16'h017F});
    chkEq("R8 pc restored", pcOut, 16'h1234);
    chkEq("R8 sp", spOut, 16'h0182 - 16'd2);

    // request during busy is dropped
    pcIn = 16'hAAAA; ccrIn = 8'h00;
    @(negedge clk); reqKind = 3'd2; vecSel = 3'd1; spIn = 16'h01F0; reqValid = 1'b1; st = logN;
    @(negedge clk); reqKind = 3'd0; targetIn = 16'h9999;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chkEq("R1 busy request ignored count", 8'(logN - st), 11);
    chkEq("R1 idle after", busy, 0);
    chkEq("R1 pc not target", pcOut, vecVal(1));

    // unused code starts nothing
    @(negedge clk); reqKind = 3'd6; reqValid = 1'b1; st = logN;
    @(negedge clk); reqValid = 1'b0;
    @(negedge clk);
    chkEq("R1 unused kind busy", busy, 0);
    chkEq("R1 unused kind no access", 8'(logN - st), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule